// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

The block keeps stores in a circular queue in program order, from allocation until the data cache accepts each write. Address, data and commit status arrive separately and in any order, addressed by the entry slot that allocation handed out. Only the oldest entry may leave, and only after it is committed and has both its address and its data. The buffer therefore holds memory's pending future state, and a store from a squashed path never reaches the cache.

A load checks the buffer in the same cycle it presents its query. The query carries the address and an age tag. The tag is the allocation pointer value the load saw when it was dispatched, so every entry allocated before that point counts as older. The answer comes back combinationally and is one of three results:
- **stall**, when the load has to wait;
- **forward**, when the buffer supplies the data;
- **bypass**, when the load may read the cache.

A load whose address is not yet translated may search with only its page-offset bits. That kind of search can prove the load is independent of the older stores, but it can never produce a forward.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, `dc_wr_valid` is 0, and any load query returns bypass.
- R2: `alloc_tag` gives the slot pointer a new store will receive; its low bits are the entry index. While DEPTH stores are held, `alloc_ready` is 0 and an allocation request changes nothing, so `alloc_tag` stays the same.
- R3: `dc_wr_valid` is asserted only when the oldest entry is committed and has both its address and its data. A committed younger entry does not make it assert.
- R4: Entries drain in allocation order and carry their own address and data. While `dc_wr_ready` is 0, the offered write stays the same; each accepted write frees one entry.
- R5: A load whose older entries include any entry with an unknown address gets stall. The result encodings are 2'b00 bypass, 2'b01 forward and 2'b10 stall.
- R6: With full-address compare, when older stores match, the youngest of them supplies `ld_data` with result forward, provided its data is present.
- R7: If the youngest matching older store has no data yet, the result is stall, never bypass.
- R8: With full-address compare and no matching older store, the result is bypass.
- R9: Entries at or after the load's tag are ignored, even when they match or their address is unknown.
- R10: With `ld_offset_only` = 1, only the low OFFW address bits are compared. A match gives stall and no match gives bypass. Forward is never returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request a new store slot |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | IDXW+1 | Pointer the next allocation receives |
| st_addr_we | input | 1 | Write a store address |
| st_addr_idx | input | IDXW | Entry for the address |
| st_addr | input | AW | Store address |
| st_data_we | input | 1 | Write store data |
| st_data_idx | input | IDXW | Entry for the data |
| st_data | input | DW | Store data |
| commit_we | input | 1 | Mark an entry committed |
| commit_idx | input | IDXW | Entry to commit |
| dc_wr_valid | output | 1 | Oldest entry offered to the cache |
| dc_wr_ready | input | 1 | Cache accepts the write |
| dc_wr_addr | output | AW | Write address |
| dc_wr_data | output | DW | Write data |
| ld_valid | input | 1 | Load query present |
| ld_tag | input | IDXW+1 | Allocation pointer seen by the load |
| ld_addr | input | AW | Load address |
| ld_offset_only | input | 1 | Compare page-offset bits only |
| ld_result | output | 2 | Bypass, forward or stall |
| ld_data | output | DW | Forwarded data |

## Verification
The search is swept over every age tag from the oldest entry to the allocation pointer. Each sweep also covers several load addresses, both high-part values and both compare modes. Store patterns are chosen to separate cases:
- two entries share an address, which shows whether the youngest match is picked over the oldest;
- one entry lacks its address, which shows a stall only for tags beyond it;
- entries lack their data, which separates a stall from a forward;
- entries differ only in the high part, which separates the offset-only result from the full-compare result.

Drain tests run with a non-zero head index. They commit younger entries first and hold the cache ready low, which shows in-order release and a stable offered write.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LD_BYPASS  = 2'b00,
    LD_FORWARD = 2'b01,
    LD_STALL   = 2'b10
  } ld_res_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic            drain_fire,
  output logic            alloc_ready,
  output logic            alloc_fire,
  output logic [PTRW-1:0] head_ptr,
  output logic [PTRW-1:0] tail_ptr
);
  logic [PTRW-1:0] head_q, head_n, tail_q, tail_n, used;

  assign used        = tail_q - head_q;
  assign alloc_ready = (used != PTRW'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign head_ptr    = head_q;
  assign tail_ptr    = tail_q;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    if (drain_fire) head_n = head_q + PTRW'(1);
    if (alloc_fire) tail_n = tail_q + PTRW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> (tail_q == $past(tail_q)));

  // R3
  drain_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_fire |-> (tail_q != head_q));
endmodule

// File: rtl/sb_entries.sv
module sb_entries #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_fire,
  input  logic [IDXW-1:0]           alloc_idx,
  input  logic                      free_fire,
  input  logic [IDXW-1:0]           free_idx,
  input  logic                      addr_we,
  input  logic [IDXW-1:0]           addr_idx,
  input  logic [AW-1:0]             addr_in,
  input  logic                      data_we,
  input  logic [IDXW-1:0]           data_idx,
  input  logic [DW-1:0]             data_in,
  input  logic                      commit_we,
  input  logic [IDXW-1:0]           commit_idx,
  output logic [DEPTH-1:0]          ent_valid,
  output logic [DEPTH-1:0]          ent_av,
  output logic [DEPTH-1:0]          ent_dv,
  output logic [DEPTH-1:0]          ent_cm,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic v_q, v_n, av_q, av_n, dv_q, dv_n, cm_q, cm_n;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic a_en, d_en;

    assign a_en = addr_we && (addr_idx == IDXW'(g));
    assign d_en = data_we && (data_idx == IDXW'(g));

    always_comb begin
      v_n  = v_q;
      av_n = av_q;
      dv_n = dv_q;
      cm_n = cm_q;
      if (free_fire && (free_idx == IDXW'(g))) v_n = 1'b0;
      if (alloc_fire && (alloc_idx == IDXW'(g))) begin
        v_n  = 1'b1;
        av_n = 1'b0;
        dv_n = 1'b0;
        cm_n = 1'b0;
      end
      if (a_en) av_n = 1'b1;
      if (d_en) dv_n = 1'b1;
      if (commit_we && (commit_idx == IDXW'(g))) cm_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        av_q <= 1'b0;
        dv_q <= 1'b0;
        cm_q <= 1'b0;
      end else begin
        v_q  <= v_n;
        av_q <= av_n;
        dv_q <= dv_n;
        cm_q <= cm_n;
      end
    end

    always_ff @(posedge clk) begin
      if (a_en) a_q <= addr_in;
      if (d_en) d_q <= data_in;
    end

    assign ent_valid[g] = v_q;
    assign ent_av[g]    = av_q;
    assign ent_dv[g]    = dv_q;
    assign ent_cm[g]    = cm_q;
    assign ent_addr[g]  = a_q;
    assign ent_data[g]  = d_q;
  end
endmodule

// File: rtl/sb_load_search.sv
module sb_load_search
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFFW = 12,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         ent_valid,
  input  logic [DEPTH-1:0]         ent_av,
  input  logic [DEPTH-1:0]         ent_dv,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [PTRW-1:0]          head_ptr,
  input  logic                     ld_valid,
  input  logic [PTRW-1:0]          ld_tag,
  input  logic [AW-1:0]            ld_addr,
  input  logic                     ld_offset_only,
  output ld_res_e                  ld_result,
  output logic [DW-1:0]            ld_data
);
  logic [PTRW-1:0] older_n;
  logic [IDXW-1:0] idx;
  logic            unknown, part_hit, hit, hit_dv;
  logic [DW-1:0]   hit_data;

  assign older_n = ld_tag - head_ptr;

  // walk oldest to youngest so the last full match wins
  always_comb begin
    unknown  = 1'b0;
    part_hit = 1'b0;
    hit      = 1'b0;
    hit_dv   = 1'b0;
    hit_data = '0;
    idx      = '0;
    for (int d = 0; d < DEPTH; d++) begin
      idx = head_ptr[IDXW-1:0] + IDXW'(d);
      if (ent_valid[idx] && (PTRW'(d) < older_n)) begin
        if (!ent_av[idx]) begin
          unknown = 1'b1;
        end else begin
          if (ent_addr[idx][OFFW-1:0] == ld_addr[OFFW-1:0]) part_hit = 1'b1;
          if (ent_addr[idx] == ld_addr) begin
            hit      = 1'b1;
            hit_dv   = ent_dv[idx];
            hit_data = ent_data[idx];
          end
        end
      end
    end
  end

  always_comb begin
    ld_result = LD_BYPASS;
    if (ld_valid) begin
      if (unknown)             ld_result = LD_STALL;
      else if (ld_offset_only) ld_result = part_hit ? LD_STALL : LD_BYPASS;
      else if (hit)            ld_result = hit_dv ? LD_FORWARD : LD_STALL;
    end
    ld_data = (ld_result == LD_FORWARD) ? hit_data : '0;
  end

  // R10
  partial_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_offset_only) |-> (ld_result != LD_FORWARD));

  // R5
  unknown_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && unknown) |-> (ld_result == LD_STALL));
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFFW = 12,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  output logic [PTRW-1:0] alloc_tag,
  input  logic            st_addr_we,
  input  logic [IDXW-1:0] st_addr_idx,
  input  logic [AW-1:0]   st_addr,
  input  logic            st_data_we,
  input  logic [IDXW-1:0] st_data_idx,
  input  logic [DW-1:0]   st_data,
  input  logic            commit_we,
  input  logic [IDXW-1:0] commit_idx,
  output logic            dc_wr_valid,
  input  logic            dc_wr_ready,
  output logic [AW-1:0]   dc_wr_addr,
  output logic [DW-1:0]   dc_wr_data,
  input  logic            ld_valid,
  input  logic [PTRW-1:0] ld_tag,
  input  logic [AW-1:0]   ld_addr,
  input  logic            ld_offset_only,
  output logic [1:0]      ld_result,
  output logic [DW-1:0]   ld_data
);
  logic [PTRW-1:0]          head_ptr, tail_ptr;
  logic                     alloc_fire, drain_fire;
  logic [IDXW-1:0]          head_idx;
  logic [DEPTH-1:0]         ent_valid, ent_av, ent_dv, ent_cm;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  ld_res_e                  res;

  assign head_idx    = head_ptr[IDXW-1:0];
  assign alloc_tag   = tail_ptr;
  assign dc_wr_valid = ent_valid[head_idx] && ent_cm[head_idx] &&
                       ent_av[head_idx] && ent_dv[head_idx];
  assign dc_wr_addr  = ent_addr[head_idx];
  assign dc_wr_data  = ent_data[head_idx];
  assign drain_fire  = dc_wr_valid && dc_wr_ready;
  assign ld_result   = res;

  sb_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .drain_fire(drain_fire), .alloc_ready(alloc_ready),
    .alloc_fire(alloc_fire), .head_ptr(head_ptr), .tail_ptr(tail_ptr)
  );

  sb_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) ent_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_idx(tail_ptr[IDXW-1:0]),
    .free_fire(drain_fire), .free_idx(head_idx),
    .addr_we(st_addr_we), .addr_idx(st_addr_idx), .addr_in(st_addr),
    .data_we(st_data_we), .data_idx(st_data_idx), .data_in(st_data),
    .commit_we(commit_we), .commit_idx(commit_idx),
    .ent_valid(ent_valid), .ent_av(ent_av), .ent_dv(ent_dv),
    .ent_cm(ent_cm), .ent_addr(ent_addr), .ent_data(ent_data)
  );

  sb_load_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OFFW(OFFW)) srch_i (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_av(ent_av), .ent_dv(ent_dv),
    .ent_addr(ent_addr), .ent_data(ent_data), .head_ptr(head_ptr),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .ld_offset_only(ld_offset_only), .ld_result(res), .ld_data(ld_data)
  );

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_wr_valid && !dc_wr_ready) |=>
      (dc_wr_valid && (dc_wr_addr == $past(dc_wr_addr)) &&
       (dc_wr_data == $past(dc_wr_data))));

  // R3
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_wr_valid |-> (ent_cm[head_idx] && ent_valid[head_idx]));
endmodule

// File: tb/store_fwd_buffer_tb_top.sv
module store_fwd_buffer_tb_top;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int OFFW = 4;
  localparam int IDXW = 2;
  localparam int PTRW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_ready;
  logic [PTRW-1:0] alloc_tag;
  logic st_addr_we, st_data_we, commit_we;
  logic [IDXW-1:0] st_addr_idx, st_data_idx, commit_idx;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic dc_wr_valid, dc_wr_ready;
  logic [AW-1:0] dc_wr_addr;
  logic [DW-1:0] dc_wr_data;
  logic ld_valid, ld_offset_only;
  logic [PTRW-1:0] ld_tag;
  logic [AW-1:0] ld_addr;
  logic [1:0] ld_result;
  logic [DW-1:0] ld_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int b_head = 0;

  bit          m_av [4];
  bit          m_dv [4];
  logic [7:0]  m_addr [4];
  logic [7:0]  m_data [4];

  always #10 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OFFW(OFFW)) dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .st_addr_we(st_addr_we), .st_addr_idx(st_addr_idx), .st_addr(st_addr),
    .st_data_we(st_data_we), .st_data_idx(st_data_idx), .st_data(st_data),
    .commit_we(commit_we), .commit_idx(commit_idx),
    .dc_wr_valid(dc_wr_valid), .dc_wr_ready(dc_wr_ready),
    .dc_wr_addr(dc_wr_addr), .dc_wr_data(dc_wr_data),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .ld_offset_only(ld_offset_only), .ld_result(ld_result), .ld_data(ld_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [1:0] slot(input int k);
    return 2'((b_head + k) % DEPTH);
  endfunction

  task automatic do_alloc();
    @(negedge clk); alloc_valid = 1'b1;
    @(posedge clk); #1 alloc_valid = 1'b0;
  endtask

  task automatic wr_addr(input int k, input logic [7:0] a);
    @(negedge clk); st_addr_we = 1'b1; st_addr_idx = slot(k); st_addr = a;
    @(posedge clk); #1 st_addr_we = 1'b0;
  endtask

  task automatic wr_data(input int k, input logic [7:0] d);
    @(negedge clk); st_data_we = 1'b1; st_data_idx = slot(k); st_data = d;
    @(posedge clk); #1 st_data_we = 1'b0;
  endtask

  task automatic do_commit(input int k);
    @(negedge clk); commit_we = 1'b1; commit_idx = slot(k);
    @(posedge clk); #1 commit_we = 1'b0;
  endtask

  // expected search result from the requirement text
  task automatic query(input int t, input logic [7:0] a, input bit part);
    int exp_res;
    int exp_dat;
    bit unk;
    bit phit;
    int youngest;
    string req;
    unk = 0; phit = 0; youngest = -1;
    for (int k = 0; k < t; k++) begin
      if (!m_av[k]) unk = 1;
      else begin
        if (m_addr[k][3:0] == a[3:0]) phit = 1;
        if (m_addr[k] == a) youngest = k;
      end
    end
    exp_dat = 0;
    if (unk) begin exp_res = 2; req = "R5"; end
    else if (part) begin exp_res = phit ? 2 : 0; req = "R10"; end
    else if (youngest >= 0) begin
      if (m_dv[youngest]) begin
        exp_res = 1; exp_dat = m_data[youngest]; req = "R6";
      end else begin exp_res = 2; req = "R7"; end
    end else begin exp_res = 0; req = (t < 4) ? "R8/R9" : "R8"; end
    @(negedge clk);
    ld_valid = 1'b1; ld_tag = PTRW'((b_head + t) % 8);
    ld_addr = a; ld_offset_only = part;
    #2;
    chk(req, ld_result, exp_res);
    if (exp_res == 1) chk("R6", ld_data, exp_dat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; st_addr_we = 0; st_data_we = 0; commit_we = 0;
    st_addr_idx = 0; st_data_idx = 0; commit_idx = 0; st_addr = 0; st_data = 0;
    dc_wr_ready = 0; ld_valid = 0; ld_tag = 0; ld_addr = 0; ld_offset_only = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    ld_valid = 1'b1; ld_addr = 8'h05; ld_tag = 3'd0;
    #2;
    chk("R1 ready", alloc_ready, 1);
    chk("R1 tag", alloc_tag, 0);
    chk("R1 drain", dc_wr_valid, 0);
    chk("R1 load", ld_result, 0);
    ld_valid = 1'b0;

    for (int r = 0; r < 5; r++) begin
      // single store that shifts the head index
      do_alloc();
      wr_addr(0, 8'hF0);
      wr_data(0, 8'hEE);
      @(negedge clk); #2 chk("R3 uncommitted", dc_wr_valid, 0);
      do_commit(0);
      @(negedge clk); dc_wr_ready = 1'b1; #2;
      chk("R3 ready head", dc_wr_valid, 1);
      chk("R4 addr", dc_wr_addr, 8'hF0);
      @(posedge clk); #1 dc_wr_ready = 1'b0;
      b_head++;

      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #2 chk("R2 tag", alloc_tag, (b_head + k) % 8);
        do_alloc();
      end
      @(negedge clk); #2 chk("R2 full", alloc_ready, 0);
      do_alloc();
      @(negedge clk); #2 chk("R2 refused", alloc_tag, (b_head + 4) % 8);

      for (int k = 0; k < 4; k++) begin
        m_addr[k] = 8'(((r * k) % 2) * 16 + ((r + k) % 3));
        m_data[k] = 8'(r * 16 + k + 1);
        m_av[k] = !(r == 1 && k == 2);
        m_dv[k] = !((r == 2 && k >= 1) || (r == 4 && k == 3));
        if (m_av[k]) wr_addr(k, m_addr[k]);
        if (m_dv[k]) wr_data(k, m_data[k]);
      end

      for (int t = 0; t <= 4; t++)
        for (int lo = 0; lo < 3; lo++)
          for (int hi = 0; hi < 2; hi++)
            for (int p = 0; p < 2; p++)
              query(t, 8'(hi * 16 + lo), p[0]);
      @(negedge clk); ld_valid = 1'b0;

      for (int k = 0; k < 4; k++) begin
        if (!m_av[k]) wr_addr(k, m_addr[k]);
        if (!m_dv[k]) wr_data(k, m_data[k]);
      end
      for (int k = 3; k >= 1; k--) do_commit(k);
      @(negedge clk); #2 chk("R3 younger committed", dc_wr_valid, 0);
      do_commit(0);

      for (int k = 0; k < 4; k++) begin
        if (k == 2) begin
          @(negedge clk); #2 chk("R4 held valid", dc_wr_valid, 1);
          @(negedge clk); #2;
          chk("R4 held addr", dc_wr_addr, m_addr[2]);
          chk("R4 held data", dc_wr_data, m_data[2]);
        end
        @(negedge clk); dc_wr_ready = 1'b1; #2;
        chk("R4 valid", dc_wr_valid, 1);
        chk("R4 addr", dc_wr_addr, m_addr[k]);
        chk("R4 data", dc_wr_data, m_data[k]);
        @(posedge clk); #1 dc_wr_ready = 1'b0;
      end
      b_head += 4;
      @(negedge clk); #2;
      chk("R4 empty", dc_wr_valid, 0);
      chk("R2 ready again", alloc_ready, 1);
    end
    finish_run();
  end
endmodule